// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block keeps wall-clock time and calendar date as packed BCD bytes and advances them once for every cycle in which its one-second tick enable is high. It holds seconds, minutes and hours in 24-hour form, a day-of-week count, the day of the month, the month, a two-digit year and a century byte. Month lengths and the February leap day are worked out from the current month and year, so carries ripple from seconds up to the century without any outside help.

A register interface around the block sets the time by presenting all eight fields on a parallel load port and pulsing a load strobe. The same interface can freeze the count with a stop control. All eight fields are registered and come out continuously, so a reader always sees a coherent snapshot that changes only at a clock edge.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes each count 0x00 to 0x59 in packed BCD (tens digit in bits 7:4, units in bits 3:0); a step from 0x59 gives 0x00 and advances the next field up by one.
- R2: Hours count 0x00 to 0x23; a step from 0x23 gives 0x00 and advances both the day of week and the day of month.
- R3: The day of week counts 0x01 to 0x07, wraps from 0x07 to 0x01, and changes only when the hours wrap.
- R4: The day of month wraps to 0x01 and advances the month after 0x31 in months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12, and after 0x30 in months 0x04, 0x06, 0x09 and 0x11.
- R5: In month 0x02 the day of month wraps after 0x29 when the year is divisible by four (year 0x00 included) and after 0x28 otherwise.
- R6: Months count 0x01 to 0x12, wrapping to 0x01 and advancing the year; the year counts 0x00 to 0x99.
- R7: A year step from 0x99 to 0x00 advances the century; the century counts 0x00 up to the BCD form of parameter CENT_LAST (default 39) and wraps from there to 0x00.
- R8: While the stop input is 1, a tick has no effect and every field holds.
- R9: A load strobe replaces all eight fields with the load port values at the next clock edge, and takes priority over a tick in the same cycle.
- R10: Reset sets time to 00:00:00, day of week 0x01, date 0x01, month 0x01, year 0x00 and century 0x00.
- R11: Fields advance by exactly one second per clock cycle with the tick enable high, and hold in cycles where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-second advance enable |
| oscStop | input | 1 | Freeze counting when 1 |
| loadStb | input | 1 | Replace all fields from the load port |
| ldSec | input | 8 | Load value, seconds |
| ldMin | input | 8 | Load value, minutes |
| ldHour | input | 8 | Load value, hours |
| ldDow | input | 8 | Load value, day of week |
| ldDate | input | 8 | Load value, day of month |
| ldMonth | input | 8 | Load value, month |
| ldYear | input | 8 | Load value, year |
| ldCent | input | 8 | Load value, century |
| secOut | output | 8 | Seconds |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hours |
| dowOut | output | 8 | Day of week |
| dateOut | output | 8 | Day of month |
| monthOut | output | 8 | Month |
| yearOut | output | 8 | Year |
| centOut | output | 8 | Century |

## Verification
The bench builds the block with the default CENT_LAST of 39, so loading century 0x39 with a year-end time brings the full carry chain, including the century wrap, within one tick. Because the load port can place the counter one second before any boundary, every month end, each leap-rule case of the year digits and the midnight carry into the day of week are reached in a handful of cycles rather than by counting through a real calendar.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NF = 8;
  localparam int FW = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  typedef struct packed {
    logic          load;
    logic [NF-1:0] adv;
    logic [NF-1:0] wrap;
  } calStrobe_t;

  function automatic logic [FW-1:0] bcdInc(input logic [FW-1:0] x);
    if (x[3:0] == 4'd9) return {x[7:4] + 4'd1, 4'd0};
    else                return {x[7:4], x[3:0] + 4'd1};
  endfunction

  function automatic logic [FW-1:0] toBcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [FW-1:0] fieldFloor(input int idx);
    return (idx == F_DOW || idx == F_DATE || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int CENT_LAST = 39
) (
  input  logic              tickEn,
  input  logic              oscStop,
  input  logic              loadStb,
  input  logic [NF-1:0][FW-1:0] curVec,
  output calStrobe_t        strobe
);
  localparam logic [FW-1:0] CENT_TOP = toBcd(CENT_LAST);

  logic [FW-1:0] monthEnd;
  logic [1:0]    yrMod4;
  logic          isLeap;
  logic [NF-1:0] atTop;

  always_comb begin
    yrMod4 = curVec[F_YEAR][1:0] + {curVec[F_YEAR][4], 1'b0};
    isLeap = (yrMod4 == 2'd0);
    case (curVec[F_MON])
      8'h02:                      monthEnd = isLeap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthEnd = 8'h30;
      default:                    monthEnd = 8'h31;
    endcase
  end

  always_comb begin
    atTop[F_SEC]  = curVec[F_SEC]  >= 8'h59;
    atTop[F_MIN]  = curVec[F_MIN]  >= 8'h59;
    atTop[F_HOUR] = curVec[F_HOUR] >= 8'h23;
    atTop[F_DOW]  = curVec[F_DOW]  >= 8'h07;
    atTop[F_DATE] = curVec[F_DATE] >= monthEnd;
    atTop[F_MON]  = curVec[F_MON]  >= 8'h12;
    atTop[F_YEAR] = curVec[F_YEAR] >= 8'h99;
    atTop[F_CENT] = curVec[F_CENT] >= CENT_TOP;
  end

  always_comb begin
    strobe.load        = loadStb;
    strobe.wrap        = atTop;
    strobe.adv[F_SEC]  = tickEn & ~oscStop & ~loadStb;
    strobe.adv[F_MIN]  = strobe.adv[F_SEC]  & atTop[F_SEC];
    strobe.adv[F_HOUR] = strobe.adv[F_MIN]  & atTop[F_MIN];
    strobe.adv[F_DOW]  = strobe.adv[F_HOUR] & atTop[F_HOUR];
    strobe.adv[F_DATE] = strobe.adv[F_HOUR] & atTop[F_HOUR];
    strobe.adv[F_MON]  = strobe.adv[F_DATE] & atTop[F_DATE];
    strobe.adv[F_YEAR] = strobe.adv[F_MON]  & atTop[F_MON];
    strobe.adv[F_CENT] = strobe.adv[F_YEAR] & atTop[F_YEAR];
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  calStrobe_t        strobe,
  input  logic [NF-1:0][FW-1:0] ldVec,
  output logic [NF-1:0][FW-1:0] curVec
);
  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam logic [FW-1:0] FLOOR = fieldFloor(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                curVec[i] <= FLOOR;
      else if (strobe.load)      curVec[i] <= ldVec[i];
      else if (strobe.adv[i])    curVec[i] <= strobe.wrap[i] ? FLOOR : bcdInc(curVec[i]);
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int CENT_LAST = 39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       oscStop,
  input  logic       loadStb,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [7:0] ldDow,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMonth,
  input  logic [7:0] ldYear,
  input  logic [7:0] ldCent,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dowOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut,
  output logic [7:0] centOut
);
  calStrobe_t            strobe;
  logic [NF-1:0][FW-1:0] ldVec;
  logic [NF-1:0][FW-1:0] curVec;

  assign ldVec = {ldCent, ldYear, ldMonth, ldDate, ldDow, ldHour, ldMin, ldSec};

  cal_ctrl #(.CENT_LAST(CENT_LAST)) u_ctrl (
    .tickEn (tickEn),
    .oscStop(oscStop),
    .loadStb(loadStb),
    .curVec (curVec),
    .strobe (strobe)
  );

  cal_datapath u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .ldVec (ldVec),
    .curVec(curVec)
  );

  assign secOut   = curVec[F_SEC];
  assign minOut   = curVec[F_MIN];
  assign hourOut  = curVec[F_HOUR];
  assign dowOut   = curVec[F_DOW];
  assign dateOut  = curVec[F_DATE];
  assign monthOut = curVec[F_MON];
  assign yearOut  = curVec[F_YEAR];
  assign centOut  = curVec[F_CENT];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tickEn,
  input logic       oscStop,
  input logic       loadStb,
  input logic [7:0] ldSec,
  input logic [7:0] ldMin,
  input logic [7:0] ldHour,
  input logic [7:0] ldDow,
  input logic [7:0] ldDate,
  input logic [7:0] ldMonth,
  input logic [7:0] ldYear,
  input logic [7:0] ldCent,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] dowOut,
  input logic [7:0] dateOut,
  input logic [7:0] monthOut,
  input logic [7:0] yearOut,
  input logic [7:0] centOut
);
  logic [63:0] nowT, ldT;
  assign nowT = {centOut, yearOut, monthOut, dateOut, dowOut, hourOut, minOut, secOut};
  assign ldT  = {ldCent, ldYear, ldMonth, ldDate, ldDow, ldHour, ldMin, ldSec};

  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !oscStop && !loadStb && secOut == 8'h59) |=> (secOut == 8'h00));

  a_r1_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!loadStb && secOut != 8'h59) |=> $stable(minOut));

  a_r2_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !oscStop && !loadStb && hourOut == 8'h23 && minOut == 8'h59
     && secOut == 8'h59) |=> (hourOut == 8'h00));

  a_r3_dow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!loadStb && hourOut != 8'h23) |=> $stable(dowOut));

  a_r7_cent_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!loadStb && yearOut != 8'h99) |=> $stable(centOut));

  a_r8_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (oscStop && !loadStb) |=> $stable(nowT));

  a_r9_load_all: assert property (@(posedge clk) disable iff (!rst_n)
    loadStb |=> (nowT == $past(ldT)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !loadStb) |=> $stable(nowT));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (.*);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0, oscStop = 1'b0, loadStb = 1'b0;
  logic [7:0] ldSec, ldMin, ldHour, ldDow, ldDate, ldMonth, ldYear, ldCent;
  logic [7:0] secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut, centOut;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_calendar uut (.*);

  wire [63:0] nowT = {centOut, yearOut, monthOut, dateOut, dowOut, hourOut, minOut, secOut};

  // Packing per row: {start, expected}, each {cent,year,month,date,dow,hour,min,sec}
  localparam logic [127:0] VEC [NV] = '{
    {64'h39_99_12_31_07_23_59_59, 64'h00_00_01_01_01_00_00_00}, // R7 R6 R3 R2 R1 full wrap
    {64'h20_23_02_28_03_23_59_59, 64'h20_23_03_01_04_00_00_00}, // R5 non-leap
    {64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00}, // R5 leap
    {64'h20_24_02_29_04_23_59_59, 64'h20_24_03_01_05_00_00_00}, // R5 leap end
    {64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00}, // R5 year 00
    {64'h20_10_02_28_01_23_59_59, 64'h20_10_03_01_02_00_00_00}, // R5 year 10
    {64'h20_12_02_28_01_23_59_59, 64'h20_12_02_29_02_00_00_00}, // R5 year 12
    {64'h20_96_02_28_01_23_59_59, 64'h20_96_02_29_02_00_00_00}, // R5 year 96
    {64'h20_05_04_30_02_23_59_59, 64'h20_05_05_01_03_00_00_00}, // R4 30-day
    {64'h20_05_04_29_02_23_59_59, 64'h20_05_04_30_03_00_00_00}, // R4 not end
    {64'h20_05_01_31_02_23_59_59, 64'h20_05_02_01_03_00_00_00}, // R4 31-day
    {64'h20_05_11_30_06_23_59_59, 64'h20_05_12_01_07_00_00_00}, // R4 November
    {64'h20_05_08_31_06_23_59_59, 64'h20_05_09_01_07_00_00_00}, // R4 August
    {64'h20_45_12_31_05_23_59_59, 64'h20_46_01_01_06_00_00_00}, // R6 year step
    {64'h20_99_12_31_05_23_59_59, 64'h21_00_01_01_06_00_00_00}, // R7 century step
    {64'h20_05_06_15_02_12_34_09, 64'h20_05_06_15_02_12_34_10}, // R1 digit carry, R3 dow holds
    {64'h20_05_06_15_02_09_59_59, 64'h20_05_06_15_02_10_00_00}  // R2 hour digit carry
  };

  task automatic check(input string tag, input logic [63:0] exp);
    checks++;
    if (nowT !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, nowT, exp);
    end
  endtask

  task automatic setLoad(input logic [63:0] v);
    {ldCent, ldYear, ldMonth, ldDate, ldDow, ldHour, ldMin, ldSec} = v;
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic t, input logic s, input logic l);
    tickEn = t; oscStop = s; loadStb = l;
    @(negedge clk);
    tickEn = 1'b0; oscStop = 1'b0; loadStb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    setLoad(64'h0);
    repeat (3) @(negedge clk);
    check("R10 reset state", 64'h00_00_01_01_01_00_00_00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      setLoad(VEC[i][127:64]);
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b0);
      check($sformatf("R1-row table row %0d", i), VEC[i][63:0]);
    end

    // R11: tick low holds, several ticks count one each
    setLoad(64'h20_05_06_15_02_00_00_58);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    check("R11 no tick hold", 64'h20_05_06_15_02_00_00_58);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R11 three ticks", 64'h20_05_06_15_02_00_01_01);

    // R8: stop with tick at a full-wrap point holds everything
    setLoad(64'h39_99_12_31_07_23_59_59);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R8 stop holds", 64'h39_99_12_31_07_23_59_59);
    step(1'b1, 1'b0, 1'b0);
    check("R8 resume after stop", 64'h00_00_01_01_01_00_00_00);

    // R9: load beats tick in same cycle
    setLoad(64'h15_37_07_04_03_11_22_33);
    step(1'b1, 1'b0, 1'b1);
    check("R9 load over tick", 64'h15_37_07_04_03_11_22_33);

    // R9: load while stopped still loads
    setLoad(64'h01_02_03_04_05_06_07_08);
    step(1'b1, 1'b1, 1'b1);
    check("R9 load while stopped", 64'h01_02_03_04_05_06_07_08);

    // R3: dow 07 wraps to 01 at midnight mid-month
    setLoad(64'h20_05_06_14_07_23_59_59);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R3 dow wrap", 64'h20_05_06_15_01_00_00_00);

    // R7: century below top advances, from 38
    setLoad(64'h38_99_12_31_01_23_59_59);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R7 century 38 to 39", 64'h39_00_01_01_02_00_00_00);

    // R10: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset mid-run", 64'h00_00_01_01_01_00_00_00);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule